// File: doc/BRIEF.md
# Quad-Lane Byte Absolute-Difference Reducer

This block takes two 32-bit source words and a 32-bit third operand, the accumulator input. It builds four byte lanes for each of two operands, A and B, by picking bytes out of the 64-bit pool formed from the two sources. Each lane reads its two bytes as signed or unsigned, as each operand's format bit directs, and forms the absolute difference. The four differences are then reduced against the accumulator input. In merge mode they replace selected bytes of it. In accumulate mode they are added to it. A 4-bit lane mask picks which lanes take part. An optional saturation switch clamps values that would otherwise wrap.

The second source can be replaced by an 8-bit immediate, which is zero-extended to 32 bits. The result and four condition flags are registered once, so they appear one clock after a valid input. An illegal reduction-mode code raises an error output and forces a zero result.

Top module: `qbad_top`

## Requirements
- R1: Byte pool index k (0..7) names bits 8k+7..8k of {second source, srcA}. When useImm is 1, the second source is {24'h0, immVal}; otherwise it is srcB. Lane i takes its A byte from index aSel[3i+2:3i] and its B byte from index bSel[3i+2:3i], and its outcome lands in result byte i.
- R2: Before subtraction, each lane byte is extended to 9 bits: sign-extended when its operand's format bit (aSigned or bSigned) is 1, zero-extended when it is 0. The lane difference is |A - B|, a value from 0 to 383.
- R3: Merge mode is mode 2'b00. Result byte i is accIn byte i when laneMask[i] is 0. Otherwise it is the low 8 bits of lane i's difference, except that a difference above 255 gives 8'hFF when satEn is 1.
- R4: Accumulate mode is mode 2'b01. The result is accIn plus the sum of the differences of lanes whose mask bit is 1, taken modulo 2^32. When satEn is 1 and the addition carries out of bit 31, the result is 32'hFFFF_FFFF instead.
- R5: zeroFlag is 1 exactly when the registered result is 0. signFlag equals result bit 31.
- R6: In accumulate mode, carryFlag is the carry out of bit 31 of the 32-bit add. ovfFlag is bit 31 of the wrapped sum XOR the sign of the exact sum, where accIn is read as two's-complement and the lane sum as non-negative. Saturation does not change either flag.
- R7: In merge mode, carryFlag and ovfFlag are both 0.
- R8: Modes 2'b10 and 2'b11 are invalid. They give modeErr = 1, result 0, zeroFlag 1, and signFlag, carryFlag and ovfFlag all 0. Valid modes give modeErr = 0.
- R9: The result, the flags and modeErr load on the clock edge where inValid is 1, and outValid is 1 in the following cycle. When inValid is 0, outValid is 0 and all other outputs hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are valid this cycle |
| srcA | input | 32 | First source word, pool bytes 0..3 |
| srcB | input | 32 | Second source word, pool bytes 4..7 |
| immVal | input | 8 | Immediate that stands in for the second source |
| useImm | input | 1 | Take the second source from immVal |
| accIn | input | 32 | Third operand, merged into or added to |
| aSigned | input | 1 | Operand A bytes are signed |
| bSigned | input | 1 | Operand B bytes are signed |
| aSel | input | 12 | Four 3-bit pool indices for the A lanes |
| bSel | input | 12 | Four 3-bit pool indices for the B lanes |
| mode | input | 2 | Reduction mode: 00 merge, 01 accumulate, others invalid |
| laneMask | input | 4 | Per-lane enable for the reduction |
| satEn | input | 1 | Saturation enable |
| outValid | output | 1 | Registered outputs were loaded last edge |
| result | output | 32 | Registered result |
| zeroFlag | output | 1 | Result is zero |
| signFlag | output | 1 | Result bit 31 |
| carryFlag | output | 1 | Carry out of the accumulate add |
| ovfFlag | output | 1 | Signed overflow of the accumulate add |
| modeErr | output | 1 | Invalid mode was presented |

## Verification
The assertions assume that mode, laneMask and accIn are stable over the single edge on which inValid is sampled. They also assume that reset is held for at least one edge before the first valid input, so every $past value they read comes from a loaded cycle. The stimulus always drives inputs on the falling edge and holds them for a full cycle. It covers all four mode codes, including the two invalid ones, and all sixteen masks. This means the merge-byte, empty-mask and invalid-mode properties each see both their triggering and their non-triggering conditions.

// File: rtl/qbad_pkg.sv
`timescale 1ns/1ps
package qbad_pkg;
  typedef enum logic [1:0] {
    MODE_MERGE = 2'b00,
    MODE_ACCUM = 2'b01,
    MODE_RSV2  = 2'b10,
    MODE_RSV3  = 2'b11
  } redMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic doMerge;
    logic doAccum;
    logic badMode;
    logic satOn;
  } dpCtrl_t;
endpackage

// File: rtl/qbad_ctrl.sv
`timescale 1ns/1ps
module qbad_ctrl
  import qbad_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   mode,
  input  logic         satEn,
  output dpCtrl_t      ctrl,
  output logic         outValid
);
  redMode_t modeCode;

  always_comb begin
    modeCode      = redMode_t'(mode);
    ctrl.load     = inValid;
    ctrl.satOn    = satEn;
    ctrl.doMerge  = (modeCode == MODE_MERGE);
    ctrl.doAccum  = (modeCode == MODE_ACCUM);
    ctrl.badMode  = (modeCode == MODE_RSV2) || (modeCode == MODE_RSV3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/qbad_lane.sv
`timescale 1ns/1ps
module qbad_lane #(
  parameter int BYTE_W = 8,
  parameter int POOL_BYTES = 8,
  localparam int SEL_W = $clog2(POOL_BYTES),
  localparam int ABS_W = BYTE_W + 1
) (
  input  logic [POOL_BYTES*BYTE_W-1:0] pool,
  input  logic [SEL_W-1:0]             aIdx,
  input  logic [SEL_W-1:0]             bIdx,
  input  logic                         aSigned,
  input  logic                         bSigned,
  input  logic                         satOn,
  output logic [ABS_W-1:0]             absOut,
  output logic [BYTE_W-1:0]            mergeOut
);
  localparam int EXT_W = BYTE_W + 1;
  localparam int DIF_W = BYTE_W + 2;

  logic [BYTE_W-1:0] aByte, bByte;
  logic [EXT_W-1:0]  aExt, bExt;
  logic [DIF_W-1:0]  diff, negDiff, magDiff;

  always_comb begin
    aByte   = pool[aIdx*BYTE_W +: BYTE_W];
    bByte   = pool[bIdx*BYTE_W +: BYTE_W];
    aExt    = {aSigned & aByte[BYTE_W-1], aByte};
    bExt    = {bSigned & bByte[BYTE_W-1], bByte};
    diff    = {aExt[EXT_W-1], aExt} - {bExt[EXT_W-1], bExt};
    negDiff = '0 - diff;
    magDiff = diff[DIF_W-1] ? negDiff : diff;
    absOut  = magDiff[ABS_W-1:0];
    mergeOut = (satOn && absOut[BYTE_W]) ? {BYTE_W{1'b1}} : absOut[BYTE_W-1:0];
  end
endmodule

// File: rtl/qbad_dp.sv
`timescale 1ns/1ps
module qbad_dp
  import qbad_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(2 * LANES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctrl,
  input  logic [WORD_W-1:0]      srcA,
  input  logic [WORD_W-1:0]      srcB,
  input  logic [BYTE_W-1:0]      immVal,
  input  logic                   useImm,
  input  logic [WORD_W-1:0]      accIn,
  input  logic                   aSigned,
  input  logic                   bSigned,
  input  logic [LANES*SEL_W-1:0] aSel,
  input  logic [LANES*SEL_W-1:0] bSel,
  input  logic [LANES-1:0]       laneMask,
  output logic [WORD_W-1:0]      result,
  output logic                   zeroFlag,
  output logic                   signFlag,
  output logic                   carryFlag,
  output logic                   ovfFlag,
  output logic                   modeErr
);
  localparam int ABS_W = BYTE_W + 1;

  logic [WORD_W-1:0]             srcBEff;
  logic [2*WORD_W-1:0]           pool;
  logic [LANES-1:0][ABS_W-1:0]   laneAbs;
  logic [LANES-1:0][BYTE_W-1:0]  laneByte;
  logic [WORD_W-1:0]             laneSum;
  logic [WORD_W-1:0]             mergeRes, accRes, nextRes;
  logic [WORD_W:0]               addFull, signedFull;
  logic                          addCarry, trueSign, ovfRaw;

  assign srcBEff = useImm ? {{(WORD_W-BYTE_W){1'b0}}, immVal} : srcB;
  assign pool    = {srcBEff, srcA};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    qbad_lane #(.BYTE_W(BYTE_W), .POOL_BYTES(2*LANES)) uLane (
      .pool     (pool),
      .aIdx     (aSel[g*SEL_W +: SEL_W]),
      .bIdx     (bSel[g*SEL_W +: SEL_W]),
      .aSigned  (aSigned),
      .bSigned  (bSigned),
      .satOn    (ctrl.satOn),
      .absOut   (laneAbs[g]),
      .mergeOut (laneByte[g])
    );
    assign mergeRes[g*BYTE_W +: BYTE_W] =
      laneMask[g] ? laneByte[g] : accIn[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++)
      if (laneMask[i]) laneSum = laneSum + WORD_W'(laneAbs[i]);
  end

  always_comb begin
    addFull    = {1'b0, accIn} + {1'b0, laneSum};
    signedFull = {accIn[WORD_W-1], accIn} + {1'b0, laneSum};
    addCarry   = addFull[WORD_W];
    trueSign   = signedFull[WORD_W];
    ovfRaw     = addFull[WORD_W-1] ^ trueSign;
    accRes     = (ctrl.satOn && addCarry) ? {WORD_W{1'b1}} : addFull[WORD_W-1:0];
    if (ctrl.badMode)      nextRes = '0;
    else if (ctrl.doMerge) nextRes = mergeRes;
    else                   nextRes = accRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      zeroFlag  <= 1'b0;
      signFlag  <= 1'b0;
      carryFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      modeErr   <= 1'b0;
    end else if (ctrl.load) begin
      result    <= nextRes;
      zeroFlag  <= (nextRes == '0);
      signFlag  <= nextRes[WORD_W-1];
      carryFlag <= ctrl.doAccum & addCarry;
      ovfFlag   <= ctrl.doAccum & ovfRaw;
      modeErr   <= ctrl.badMode;
    end
  end
endmodule

// File: rtl/qbad_top.sv
`timescale 1ns/1ps
module qbad_top
  import qbad_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(2 * LANES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [WORD_W-1:0]      srcA,
  input  logic [WORD_W-1:0]      srcB,
  input  logic [BYTE_W-1:0]      immVal,
  input  logic                   useImm,
  input  logic [WORD_W-1:0]      accIn,
  input  logic                   aSigned,
  input  logic                   bSigned,
  input  logic [LANES*SEL_W-1:0] aSel,
  input  logic [LANES*SEL_W-1:0] bSel,
  input  logic [1:0]             mode,
  input  logic [LANES-1:0]       laneMask,
  input  logic                   satEn,
  output logic                   outValid,
  output logic [WORD_W-1:0]      result,
  output logic                   zeroFlag,
  output logic                   signFlag,
  output logic                   carryFlag,
  output logic                   ovfFlag,
  output logic                   modeErr
);
  dpCtrl_t ctrl;

  qbad_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .satEn    (satEn),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  qbad_dp #(.LANES(LANES), .BYTE_W(BYTE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcA      (srcA),
    .srcB      (srcB),
    .immVal    (immVal),
    .useImm    (useImm),
    .accIn     (accIn),
    .aSigned   (aSigned),
    .bSigned   (bSigned),
    .aSel      (aSel),
    .bSel      (bSel),
    .laneMask  (laneMask),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .signFlag  (signFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .modeErr   (modeErr)
  );
endmodule

// File: rtl/qbad_chk.sv
`timescale 1ns/1ps
module qbad_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        mode,
  input logic [LANES-1:0]  laneMask,
  input logic [WORD_W-1:0] accIn,
  input logic              outValid,
  input logic [WORD_W-1:0] result,
  input logic              zeroFlag,
  input logic              signFlag,
  input logic              carryFlag,
  input logic              ovfFlag,
  input logic              modeErr
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(modeErr)));

  a_r7_merge_no_cv: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'b00) |=> (!carryFlag && !ovfFlag));

  a_r8_bad_mode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode[1]) |=> (modeErr && result == '0 && zeroFlag && !signFlag));

  a_r8_good_mode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !mode[1]) |=> !modeErr);

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'b01 && laneMask == '0) |=>
      (result == $past(accIn) && !carryFlag && !ovfFlag));

  for (genvar g = 0; g < LANES; g++) begin : gByte
    a_r3_masked_byte: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && mode == 2'b00 && !laneMask[g]) |=>
        (result[g*BYTE_W +: BYTE_W] == $past(accIn[g*BYTE_W +: BYTE_W])));
  end

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (zeroFlag == (result == '0)));

  a_r5_sign_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (signFlag == result[WORD_W-1]));
endmodule

bind qbad_top qbad_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .mode      (mode),
  .laneMask  (laneMask),
  .accIn     (accIn),
  .outValid  (outValid),
  .result    (result),
  .zeroFlag  (zeroFlag),
  .signFlag  (signFlag),
  .carryFlag (carryFlag),
  .ovfFlag   (ovfFlag),
  .modeErr   (modeErr)
);

// File: tb/qbad_top_test.sv
`timescale 1ns/1ps
module qbad_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcA = '0, srcB = '0, accIn = '0;
  logic [7:0]  immVal = '0;
  logic        useImm = 1'b0, aSigned = 1'b0, bSigned = 1'b0, satEn = 1'b0;
  logic [11:0] aSel = '0, bSel = '0;
  logic [1:0]  mode = '0;
  logic [3:0]  laneMask = '0;
  logic        outValid, zeroFlag, signFlag, carryFlag, ovfFlag, modeErr;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [11:0] SEL_LO = {3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [11:0] SEL_HI = {3'd7, 3'd6, 3'd5, 3'd4};

  always #2.5 clk = ~clk;

  qbad_top uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .immVal(immVal), .useImm(useImm), .accIn(accIn), .aSigned(aSigned),
    .bSigned(bSigned), .aSel(aSel), .bSel(bSel), .mode(mode),
    .laneMask(laneMask), .satEn(satEn), .outValid(outValid),
    .result(result), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .carryFlag(carryFlag), .ovfFlag(ovfFlag), .modeErr(modeErr)
  );

  // {err, zero, sign, carry, ovf, result}
  function automatic logic [36:0] model();
    logic [63:0] pool;
    logic [31:0] mres, raw, res;
    longint      sum, tu, ts;
    int          ia, ib, av, bv, d;
    logic        cy, ov;
    pool = {(useImm ? {24'h0, immVal} : srcB), srcA};
    sum = 0;
    mres = accIn;
    for (int l = 0; l < 4; l++) begin
      ia = int'(aSel[3*l +: 3]);
      ib = int'(bSel[3*l +: 3]);
      av = int'(pool[8*ia +: 8]);
      bv = int'(pool[8*ib +: 8]);
      if (aSigned && av >= 128) av = av - 256;
      if (bSigned && bv >= 128) bv = bv - 256;
      d = (av > bv) ? av - bv : bv - av;
      if (laneMask[l]) begin
        sum = sum + d;
        mres[8*l +: 8] = (satEn && d > 255) ? 8'hFF : 8'(d);
      end
    end
    tu = longint'({32'h0, accIn}) + sum;
    ts = longint'($signed(accIn)) + sum;
    raw = tu[31:0];
    cy = tu[32];
    ov = raw[31] ^ (ts < 0);
    if (mode == 2'b00)      begin res = mres; cy = 0; ov = 0; end
    else if (mode == 2'b01) res = (satEn && cy) ? 32'hFFFF_FFFF : raw;
    else return {1'b1, 1'b1, 3'b000, 32'h0};
    return {1'b0, res == 32'h0, res[31], cy, ov, res};
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive valid at current negedge, check one cycle later
  task automatic apply(input string tag);
    logic [36:0] exp;
    exp = model();
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, {modeErr, zeroFlag, signFlag, carryFlag, ovfFlag, result}, exp);
    check("R9 valid", {36'h0, outValid}, 37'h1);
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R3 merge";
      2'b01: return "R4 accum";
      default: return "R8 invalid";
    endcase
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {outValid, modeErr, zeroFlag, signFlag, carryFlag, ovfFlag, result},
          37'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {outValid, result}, 33'h0);

    // R2: format sweep over lane byte values, merge mode, all lanes
    aSel = SEL_LO; bSel = SEL_HI; mode = 2'b00; laneMask = 4'hF; accIn = 32'h5A5A5A5A;
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        for (int f = 0; f < 4; f++) begin
          srcA = {8'(a + 200), 8'(a + 101), 8'(a + 37), 8'(a)};
          srcB = {8'(b + 9), 8'(b + 150), 8'(b + 53), 8'(b)};
          aSigned = f[0]; bSigned = f[1]; satEn = (a + b) % 2 == 1;
          apply("R2 format");
        end

    // R2 extremes: signed -128 vs unsigned 255 gives 383
    srcA = 32'h80808080; srcB = 32'hFFFFFFFF; aSigned = 1; bSigned = 0;
    satEn = 0; apply("R2 max diff wrap");
    satEn = 1; apply("R2 max diff sat");
    mode = 2'b01; satEn = 0; accIn = 0; apply("R2 max diff accum");

    // R1: selection sweep, register and immediate second source
    mode = 2'b00; laneMask = 4'hF; satEn = 0; aSigned = 0; bSigned = 1;
    srcA = 32'h13_F7_42_08; srcB = 32'hC1_6E_99_25; immVal = 8'hB3;
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        for (int u = 0; u < 2; u++) begin
          aSel = {3'(x + 3), 3'(x + 2), 3'(x + 1), 3'(x)};
          bSel = {3'(y), 3'(y + 5), 3'(y + 2), 3'(y + 7)};
          useImm = u[0];
          apply("R1 select");
        end
    useImm = 0;

    // R3/R4/R7/R8: every mode, mask and saturation setting
    lfsr = 32'hACE1_2357;
    aSel = SEL_LO; bSel = SEL_HI;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 16; k++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 4; p++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            srcA = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            srcB = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            accIn = (p == 3) ? 32'hFFFF_FF80 : lfsr;
            aSigned = p[0]; bSigned = p[1];
            mode = 2'(m); laneMask = 4'(k); satEn = s[0];
            apply(modeTag(mode));
          end

    // R6: carry and overflow boundaries in accumulate mode
    mode = 2'b01; laneMask = 4'hF; aSigned = 0; bSigned = 0;
    srcA = 32'hFFFFFFFF; srcB = 32'h00000000;   // each lane 255, sum 1020
    for (int q = 0; q < 6; q++)
      for (int s = 0; s < 2; s++) begin
        case (q)
          0: accIn = 32'h7FFF_FF00;
          1: accIn = 32'h7FFF_FC03;
          2: accIn = 32'hFFFF_FC04;
          3: accIn = 32'hFFFF_FC03;
          4: accIn = 32'h8000_0000;
          default: accIn = 32'hFFFF_FFFF;
        endcase
        satEn = s[0];
        apply("R6 carry/ovf");
      end

    // R5: zero result in both valid modes
    srcA = 32'h11223344; srcB = 32'h11223344; accIn = 32'h0;
    mode = 2'b00; laneMask = 4'hF; apply("R5 zero merge");
    mode = 2'b01; apply("R5 zero accum");
    srcA = 32'hFFFFFFFF; srcB = 32'h0; accIn = 32'hFFFF_FC04; satEn = 0;
    apply("R5 zero by wrap");

    // R9: hold while inValid is low
    mode = 2'b01; accIn = 32'h8000_0000; srcA = 32'h01020304; srcB = 0;
    apply("R9 load");
    held = result;
    inValid = 1'b0;
    srcA = 32'hDEADBEEF; accIn = 32'h0; mode = 2'b10;
    @(posedge clk); @(negedge clk);
    check("R9 hold", {modeErr, outValid, result}, {2'b00, held});
    @(posedge clk); @(negedge clk);
    check("R9 hold again", {signFlag, outValid, result}, {2'b10, held});

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule